// File: doc/BRIEF.md
# Multi-Device Sync Clock Aligner

This block divides a fast system clock by four to produce a slow synchronization clock, `syncClk`. Its phase can be moved forward one system-clock cycle at a time. The aim is to make the slow clocks of several devices that share one system clock rise on the same edge. One device acts as master and drives its `syncClk` to the `syncIn` pin of every slave.

Three ways of moving the phase are offered:

- **Automatic mode.** The slave compares each detected rising edge of `syncIn` with its own divider phase. It slips one cycle per period until the two agree, then raises `locked`.
- **Hardware manual mode.** Every detected rising edge of `syncIn` slips the phase by one cycle.
- **Software manual mode.** A strobe sets a pending-advance bit. That bit applies exactly one slip and then clears itself.

`syncIn` passes through a two-flop synchronizer and a rising-edge detector before either automatic or hardware mode uses it. When several mode bits are set, automatic mode wins, then hardware manual mode, then software manual mode.

Top module: `syncClkAligner`

## Requirements
- R1: While `rstN` is low and on the first cycle after its release, `syncClk` is 1 and `locked` and `swAdvPending` are 0. The internal divider phase starts at 0, and `syncClk` is 1 for phases 0 and 1 and 0 for phases 2 and 3.
- R2: With `autoEn` and `hwManEn` low and no advance pending, `syncClk` repeats high for two cycles and low for two cycles (period 4).
- R3: An advance makes the divider skip one count, so the next `syncClk` rising edge comes one system-clock cycle early (that period lasts 3 cycles).
- R4: A `swAdvSet` pulse sets `swAdvPending` on the next edge. If `autoEn` and `hwManEn` are both low at the following edge, one advance is applied there and `swAdvPending` clears.
- R5: While `autoEn` or `hwManEn` is high, a pending software advance is held (`swAdvPending` stays 1) and no advance is applied from it.
- R6: In hardware manual mode (`hwManEn`=1, `autoEn`=0), each rising edge of `syncIn` gives exactly one advance. The advance lands on the third system-clock edge after `syncIn` rises. A `syncIn` level held high gives no further advances.
- R7: In automatic mode, a detected `syncIn` rise that finds the divider out of step applies one advance and clears `locked`. The divider is in step when it is at phase 2, which accounts for the two synchronizer stages.
- R8: In automatic mode, a detected `syncIn` rise that finds the divider in step sets `locked`. A slave fed from a master's `syncClk` reaches lock and then has `syncClk` equal to the master's.
- R9: With both `autoEn` and `hwManEn` high, the automatic behaviour governs, so a locked slave takes no advances.
- R10: `locked` is 0 on every cycle after an edge at which `autoEn` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Master sync clock (auto mode) or slip pulse (hardware mode), asynchronous |
| autoEn | input | 1 | Automatic alignment mode enable |
| hwManEn | input | 1 | Hardware manual slip mode enable |
| swAdvSet | input | 1 | One-cycle strobe that sets the software advance bit |
| syncClk | output | 1 | Divided sync clock, system clock / 4 |
| locked | output | 1 | Automatic mode has found the divider in step with `syncIn` |
| swAdvPending | output | 1 | Software advance bit, self-clearing |

## Verification
A wrong divider phase shows at `syncClk` within four cycles as a shifted edge, because the bench model predicts every cycle of the divided clock. A lost or extra advance leaves a permanent phase offset. A wrong synchronizer depth or lock phase shows as `locked` taking the wrong value at the third edge after a `syncIn` rise. A slave fed by the bench's master model never matches that master if either fault is present. A pending bit that is not held or not cleared differs from the model on the very next cycle.

// File: rtl/syncAlignPkg.sv
package syncAlignPkg;

  // Strobes from the control to the divider datapath
  typedef struct packed {
    logic advance;  // skip one divider count this edge
  } alignCmd_t;

endpackage

// File: rtl/phaseDiv.sv
module phaseDiv
  import syncAlignPkg::*;
#(
  parameter int DIV_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  alignCmd_t           cmd,
  output logic [DIV_LOG2-1:0] phase,
  output logic                syncClk
);

  localparam int DW = DIV_LOG2;
  localparam logic [DW-1:0] STEP_ONE = DW'(1);
  localparam logic [DW-1:0] STEP_TWO = DW'(2);

  logic [DW-1:0] phaseNext;

  always_comb begin
    phaseNext = phase + (cmd.advance ? STEP_TWO : STEP_ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      syncClk <= 1'b1;
    end else begin
      phase   <= phaseNext;
      syncClk <= ~phaseNext[DW-1];
    end
  end

endmodule

// File: rtl/alignCtrl.sv
module alignCtrl
  import syncAlignPkg::*;
#(
  parameter int DIV_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncIn,
  input  logic                autoEn,
  input  logic                hwManEn,
  input  logic                swAdvSet,
  input  logic [DIV_LOG2-1:0] phase,
  output alignCmd_t           cmd,
  output logic                locked,
  output logic                swAdvPending
);

  localparam int DW         = DIV_LOG2;
  localparam int DIV        = 1 << DIV_LOG2;
  localparam int LOCK_PHASE = SYNC_STAGES % DIV;
  localparam logic [DW-1:0] LOCK_VAL = DW'(LOCK_PHASE);

  // synchronizer stages plus one flop for edge detection
  logic [SYNC_STAGES:0] syncPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= 1'b0;
    else       syncPipe[0] <= syncIn;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[g] <= 1'b0;
      else       syncPipe[g] <= syncPipe[g-1];
    end
  end

  logic syncRise;
  logic phaseMatch;
  logic modeAuto, modeHw, modeSw;
  logic swApply;

  always_comb begin
    syncRise    = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];
    phaseMatch  = (phase == LOCK_VAL);
    modeAuto    = autoEn;
    modeHw      = ~autoEn & hwManEn;
    modeSw      = ~autoEn & ~hwManEn;
    swApply     = modeSw & swAdvPending;
    cmd.advance = (modeAuto & syncRise & ~phaseMatch)
                | (modeHw & syncRise)
                | swApply;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked       <= 1'b0;
      swAdvPending <= 1'b0;
    end else begin
      if (!autoEn)       locked <= 1'b0;
      else if (syncRise) locked <= phaseMatch;
      swAdvPending <= (swAdvPending & ~swApply) | swAdvSet;
    end
  end

endmodule

// File: rtl/syncClkAligner.sv
module syncClkAligner
  import syncAlignPkg::*;
#(
  parameter int DIV_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic autoEn,
  input  logic hwManEn,
  input  logic swAdvSet,
  output logic syncClk,
  output logic locked,
  output logic swAdvPending
);

  localparam int DW = DIV_LOG2;

  alignCmd_t     cmd;
  logic [DW-1:0] phaseVal;

  alignCtrl #(
    .DIV_LOG2   (DIV_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .syncIn      (syncIn),
    .autoEn      (autoEn),
    .hwManEn     (hwManEn),
    .swAdvSet    (swAdvSet),
    .phase       (phaseVal),
    .cmd         (cmd),
    .locked      (locked),
    .swAdvPending(swAdvPending)
  );

  phaseDiv #(
    .DIV_LOG2(DIV_LOG2)
  ) u_div (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .phase  (phaseVal),
    .syncClk(syncClk)
  );

endmodule

// File: rtl/syncClkAligner_chk.sv
module syncClkAligner_chk #(
  parameter int DW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          autoEn,
  input logic          hwManEn,
  input logic          swAdvSet,
  input logic          swAdvPending,
  input logic          locked,
  input logic [DW-1:0] phase
);

  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  // R2
  idle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!autoEn && !hwManEn && !swAdvPending) |=> (phase == $past(phase) + ONE));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((phase == $past(phase) + ONE) || (phase == $past(phase) + TWO)));

  // R4
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swAdvPending && !autoEn && !hwManEn && !swAdvSet) |=> !swAdvPending);

  // R5
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swAdvPending && (autoEn || hwManEn)) |=> swAdvPending);

  // R10
  lock_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoEn |=> !locked);

  // R8
  lock_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(autoEn));

endmodule

bind syncClkAligner syncClkAligner_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .autoEn      (autoEn),
  .hwManEn     (hwManEn),
  .swAdvSet    (swAdvSet),
  .swAdvPending(swAdvPending),
  .locked      (locked),
  .phase       (phaseVal)
);

// File: tb/test_syncClkAligner.sv
module test_syncClkAligner;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic autoEn = 1'b0;
  logic hwManEn = 1'b0;
  logic swAdvSet = 1'b0;
  logic syncClk, locked, swAdvPending;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit running = 0;
  string curReq = "R1";

  // master model
  bit masterOn = 0;
  int mPhase = 0;
  bit masterCmp = 0;

  // reference model state
  int refPhase, refLocked, refPend;
  int hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  syncClkAligner i_syncClkAligner (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .autoEn(autoEn),
    .hwManEn(hwManEn), .swAdvSet(swAdvSet), .syncClk(syncClk),
    .locked(locked), .swAdvPending(swAdvPending)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      refPhase = 0; refLocked = 0; refPend = 0;
      hist = {0, 0, 0};
    end else begin
      bit rise, adv, apply;
      rise = (hist[1] == 1) && (hist[2] == 0);
      adv = 0;
      apply = 0;
      if (autoEn) begin
        if (rise) begin
          if (refPhase == 2) refLocked = 1;
          else begin adv = 1; refLocked = 0; end
        end
      end else begin
        refLocked = 0;
        if (hwManEn) begin
          if (rise) adv = 1;
        end else if (refPend == 1) begin
          adv = 1; apply = 1;
        end
      end
      if (apply) refPend = 0;
      if (swAdvSet) refPend = 1;
      refPhase = (refPhase + (adv ? 2 : 1)) % 4;
      hist.push_front(int'(syncIn));
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison and master drive, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      check(syncClk == (refPhase < 2), curReq, "syncClk", syncClk, refPhase < 2);
      check(locked == refLocked[0], curReq, "locked", locked, refLocked);
      check(swAdvPending == refPend[0], curReq, "swAdvPending", swAdvPending, refPend);
    end
    if (masterOn) begin
      mPhase = (mPhase + 1) % 4;
      syncIn = (mPhase < 2);
      if (masterCmp)
        check(syncClk == (mPhase < 2), "R8", "slave vs master syncClk", syncClk, mPhase < 2);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        step(3);
        // R1: reset state
        check(syncClk == 1'b1, "R1", "syncClk in reset", syncClk, 1);
        check(locked == 1'b0, "R1", "locked in reset", locked, 0);
        check(swAdvPending == 1'b0, "R1", "pending in reset", swAdvPending, 0);
        rstN = 1'b1;
        running = 1;
        curReq = "R1";
        step(1);
        curReq = "R2";
        step(12);

        // R4 / R3: software advance with no other mode
        curReq = "R4";
        swAdvSet = 1'b1; step(1); swAdvSet = 1'b0;
        check(swAdvPending == 1'b1, "R4", "pending after strobe", swAdvPending, 1);
        step(1);
        check(swAdvPending == 1'b0, "R4", "pending self-clear", swAdvPending, 0);
        curReq = "R3";
        step(10);

        // R5: held while hardware mode is on
        curReq = "R5";
        hwManEn = 1'b1;
        swAdvSet = 1'b1; step(1); swAdvSet = 1'b0;
        step(8);
        check(swAdvPending == 1'b1, "R5", "pending held in hw mode", swAdvPending, 1);
        hwManEn = 1'b0;
        step(6);

        // R6: hardware slips on syncIn rises, level ignored
        curReq = "R6";
        hwManEn = 1'b1;
        syncIn = 1'b1; step(3); syncIn = 1'b0; step(5);
        syncIn = 1'b1; step(1); syncIn = 1'b0; step(6);
        syncIn = 1'b1; step(14); syncIn = 1'b0; step(6);
        hwManEn = 1'b0;
        step(4);

        // R7 / R8: automatic lock to a master
        curReq = "R7";
        mPhase = 1;
        masterOn = 1;
        autoEn = 1'b1;
        step(40);
        curReq = "R8";
        check(locked == 1'b1, "R8", "locked after acquisition", locked, 1);
        masterCmp = 1;
        step(12);

        // R9: automatic wins over hardware
        curReq = "R9";
        hwManEn = 1'b1;
        step(20);
        check(locked == 1'b1, "R9", "lock kept with hw bit set", locked, 1);

        // R10: leaving automatic mode drops lock
        curReq = "R10";
        masterCmp = 0;
        autoEn = 1'b0;
        hwManEn = 1'b0;
        step(1);
        check(locked == 1'b0, "R10", "locked after auto off", locked, 0);
        masterOn = 0;
        syncIn = 1'b0;
        step(8);
        running = 0;
      end
      begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule